// File: doc/BRIEF.md
# Low-Power Operating Mode Controller

This block sequences a microcontroller between five operating modes: active, sleep, subactive, subsleep and standby. The CPU requests entry with a one-cycle sleep pulse. A standby-select bit and the block's present speed state decide which low-power mode is entered. From any of the three low-power modes, a qualified interrupt returns the block to a running mode. A destination bit chooses whether that mode is active or subactive. A one-cycle wake pulse toward the CPU marks every exit.

The oscillators, the CPU core and the peripherals are outside the block. It drives only their controls:
- a main-oscillator enable and a subclock-oscillator enable;
- a CPU instruction-clock gate;
- a vector of peripheral reset lines, for the serial port, the converter and the fast timer;
- an I/O high-impedance control;
- the peripheral clock divider that applies while sleeping.

A 3-bit status output reports the current mode.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the mode is active. Mode status uses 0 = active, 1 = sleep, 2 = subactive, 3 = subsleep and 4 = standby. After reset the status is 0, both oscillator enables and the CPU clock enable are 1, and the reset lines, the high-impedance control and the wake pulse are 0.
- R2: In active mode, a sleep pulse moves to sleep (status 1) at the next clock edge when standby_sel is 0. It moves to standby (status 4) when standby_sel is 1.
- R3: In subactive mode, a sleep pulse moves to subsleep (status 3) when standby_sel is 0. It moves to standby (status 4) when standby_sel is 1.
- R4: In sleep, subsleep or standby, the block leaves at the next edge only if irq_mask is 0 and at least one bit i has both irq_req[i] and irq_en[i] set. Any other request pattern leaves the mode unchanged.
- R5: An exit goes to active (status 0) when low_speed_sel is 0 and to subactive (status 2) when it is 1.
- R6: wake_pulse is 1 for exactly the first cycle of the mode entered by an exit, and 0 at all other times.
- R7: sys_osc_en is 1 only in active and sleep. sub_osc_en is 1 in every mode.
- R8: cpu_clk_en is 1 only in active and subactive.
- R9: With the default reset mask, every periph_rst bit is 1 in subactive, subsleep and standby, and 0 in active and sleep.
- R10: io_hiz is 1 only in standby.
- R11: In sleep, periph_div equals the div_sel value sampled on the entry edge. Later changes of div_sel have no effect until the next entry. In every other mode periph_div is 0.
- R12: A sleep pulse in sleep, subsleep or standby is ignored. A qualified interrupt in active or subactive is ignored: the mode does not change and no wake pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | One-cycle low-power entry request |
| standby_sel | input | 1 | Choose standby instead of sleep/subsleep |
| low_speed_sel | input | 1 | Exit destination: 0 active, 1 subactive |
| div_sel | input | DIVW | Peripheral divider for sleep mode |
| irq_mask | input | 1 | Global CPU interrupt mask (1 blocks wake) |
| irq_req | input | NIRQ | Per-source interrupt requests |
| irq_en | input | NIRQ | Per-source interrupt enables |
| sys_osc_en | output | 1 | Main oscillator enable |
| sub_osc_en | output | 1 | Subclock oscillator enable |
| cpu_clk_en | output | 1 | CPU instruction clock gate |
| periph_rst | output | NRST | Peripheral reset lines |
| io_hiz | output | 1 | Force I/O drivers to high impedance |
| periph_div | output | DIVW | Active peripheral divider select |
| wake_pulse | output | 1 | One-cycle exit notification |
| mode_status | output | 3 | Current mode encoding |

## Verification
An entry request and a qualified wake can arrive in the same cycle. The outcome depends on the mode in which they meet. In sleep, the bench raises both in one cycle and expects the exit to win, with the pulse set and the sleep pulse discarded. In active, it holds a qualified interrupt pending while pulsing entry. It then expects one cycle of sleep, judged by status, oscillator and divider outputs, followed by an exit with a wake pulse on the next edge.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
   typedef enum logic [2:0] {
      M_ACT    = 3'd0,
      M_SLP    = 3'd1,
      M_SUBACT = 3'd2,
      M_SUBSLP = 3'd3,
      M_STBY   = 3'd4
   } lpm_mode_e;
endpackage

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual #(
   parameter int NIRQ = 8
) (
   input  logic [NIRQ-1:0] irq_req,
   input  logic [NIRQ-1:0] irq_en,
   input  logic            irq_mask,
   output logic            wake_ok
);
   initial begin
      if (NIRQ < 1) $error("NIRQ must be at least 1");
   end

   logic [NIRQ-1:0] hit;

   for (genvar i = 0; i < NIRQ; i++) begin : g_src
      assign hit[i] = irq_req[i] & irq_en[i];
   end

   assign wake_ok = !irq_mask && (|hit);
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
   import lpm_pkg::*;
#(
   parameter int DIVW = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sleep_req,
   input  logic            standby_sel,
   input  logic            low_speed_sel,
   input  logic            wake_ok,
   input  logic [DIVW-1:0] div_sel,
   output lpm_mode_e       mode,
   output logic [DIVW-1:0] div_q,
   output logic            wake_pulse
);
   lpm_mode_e       nxt;
   logic [DIVW-1:0] div_d;
   logic            pulse_d;
   logic            low_pwr;

   assign low_pwr = (mode == M_SLP) || (mode == M_SUBSLP) || (mode == M_STBY);

   always_comb begin
      nxt     = mode;
      div_d   = div_q;
      pulse_d = 1'b0;
      case (mode)
         M_ACT: begin
            if (sleep_req) begin
               nxt = standby_sel ? M_STBY : M_SLP;
               if (!standby_sel) div_d = div_sel;
            end
         end
         M_SUBACT: begin
            if (sleep_req) nxt = standby_sel ? M_STBY : M_SUBSLP;
         end
         M_SLP, M_SUBSLP, M_STBY: begin
            if (wake_ok) begin
               nxt     = low_speed_sel ? M_SUBACT : M_ACT;
               pulse_d = 1'b1;
            end
         end
         default: nxt = M_ACT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode       <= M_ACT;
         div_q      <= '0;
         wake_pulse <= 1'b0;
      end else begin
         mode       <= nxt;
         div_q      <= div_d;
         wake_pulse <= pulse_d;
      end
   end

   // R6: the pulse never lasts two cycles
   p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |=> !wake_pulse);

   // R5: the pulse only ever accompanies a running mode
   p_pulse_dest_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |-> (mode == M_ACT || mode == M_SUBACT));

   // R2: an entry request in active leaves active
   p_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_ACT && sleep_req) |=> (mode == M_SLP || mode == M_STBY));

   // R4: without a qualified wake, a low-power mode is held
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (low_pwr && !wake_ok) |=> $stable(mode));
endmodule

// File: rtl/lpm_out_dec.sv
module lpm_out_dec
   import lpm_pkg::*;
#(
   parameter int             NRST     = 3,
   parameter int             DIVW     = 3,
   parameter logic [NRST-1:0] RST_MASK = '1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  lpm_mode_e       mode,
   input  logic [DIVW-1:0] div_q,
   output logic            sys_osc_en,
   output logic            sub_osc_en,
   output logic            cpu_clk_en,
   output logic [NRST-1:0] periph_rst,
   output logic            io_hiz,
   output logic [DIVW-1:0] periph_div
);
   initial begin
      if (NRST < 1) $error("NRST must be at least 1");
      if (DIVW < 1) $error("DIVW must be at least 1");
   end

   logic slow;

   assign slow       = (mode == M_SUBACT) || (mode == M_SUBSLP) || (mode == M_STBY);
   assign sys_osc_en = (mode == M_ACT) || (mode == M_SLP);
   assign sub_osc_en = 1'b1;
   assign cpu_clk_en = (mode == M_ACT) || (mode == M_SUBACT);
   assign io_hiz     = (mode == M_STBY);
   assign periph_div = (mode == M_SLP) ? div_q : '0;

   for (genvar k = 0; k < NRST; k++) begin : g_rst
      if (RST_MASK[k]) begin : g_held
         assign periph_rst[k] = slow;
      end else begin : g_kept
         assign periph_rst[k] = 1'b0;
      end
   end

   // R10: high impedance only with the CPU stopped and main oscillator off
   p_hiz_r10: assert property (@(posedge clk) disable iff (!rst_n)
      io_hiz |-> (!cpu_clk_en && !sys_osc_en));

   // R11: the divider does not move while sleep continues
   p_div_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_SLP && $past(mode) == M_SLP) |-> $stable(periph_div));

   // R7: the subclock oscillator is never disabled
   p_subosc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sub_osc_en);
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
   import lpm_pkg::*;
#(
   parameter int              NIRQ     = 8,
   parameter int              NRST     = 3,
   parameter int              DIVW     = 3,
   parameter logic [NRST-1:0] RST_MASK = '1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sleep_req,
   input  logic            standby_sel,
   input  logic            low_speed_sel,
   input  logic [DIVW-1:0] div_sel,
   input  logic            irq_mask,
   input  logic [NIRQ-1:0] irq_req,
   input  logic [NIRQ-1:0] irq_en,
   output logic            sys_osc_en,
   output logic            sub_osc_en,
   output logic            cpu_clk_en,
   output logic [NRST-1:0] periph_rst,
   output logic            io_hiz,
   output logic [DIVW-1:0] periph_div,
   output logic            wake_pulse,
   output logic [2:0]      mode_status
);
   lpm_mode_e       mode;
   logic [DIVW-1:0] div_q;
   logic            wake_ok;

   lpm_wake_qual #(.NIRQ(NIRQ)) u_qual (
      .irq_req  (irq_req),
      .irq_en   (irq_en),
      .irq_mask (irq_mask),
      .wake_ok  (wake_ok)
   );

   lpm_fsm #(.DIVW(DIVW)) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .sleep_req     (sleep_req),
      .standby_sel   (standby_sel),
      .low_speed_sel (low_speed_sel),
      .wake_ok       (wake_ok),
      .div_sel       (div_sel),
      .mode          (mode),
      .div_q         (div_q),
      .wake_pulse    (wake_pulse)
   );

   lpm_out_dec #(.NRST(NRST), .DIVW(DIVW), .RST_MASK(RST_MASK)) u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (mode),
      .div_q      (div_q),
      .sys_osc_en (sys_osc_en),
      .sub_osc_en (sub_osc_en),
      .cpu_clk_en (cpu_clk_en),
      .periph_rst (periph_rst),
      .io_hiz     (io_hiz),
      .periph_div (periph_div)
   );

   assign mode_status = mode;

   // R12: an exit pulse cannot follow a running mode's cycle
   p_no_run_wake_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_ACT || mode == M_SUBACT) |=> !wake_pulse);
endmodule

// File: tb/lpm_ctrl_tb.sv
`timescale 1ns/1ps
module lpm_ctrl_tb;
   localparam int NIRQ = 8;
   localparam int NRST = 3;
   localparam int DIVW = 3;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            sleep_req, standby_sel, low_speed_sel, irq_mask;
   logic [DIVW-1:0] div_sel;
   logic [NIRQ-1:0] irq_req, irq_en;
   logic            sys_osc_en, sub_osc_en, cpu_clk_en, io_hiz, wake_pulse;
   logic [NRST-1:0] periph_rst;
   logic [DIVW-1:0] periph_div;
   logic [2:0]      mode_status;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   lpm_ctrl #(.NIRQ(NIRQ), .NRST(NRST), .DIVW(DIVW)) u_dut (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .standby_sel(standby_sel),
      .low_speed_sel(low_speed_sel), .div_sel(div_sel), .irq_mask(irq_mask),
      .irq_req(irq_req), .irq_en(irq_en), .sys_osc_en(sys_osc_en),
      .sub_osc_en(sub_osc_en), .cpu_clk_en(cpu_clk_en), .periph_rst(periph_rst),
      .io_hiz(io_hiz), .periph_div(periph_div), .wake_pulse(wake_pulse),
      .mode_status(mode_status)
   );

   task automatic check(input int act, input int exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   // expected outputs derived from the mode encoding in the requirements
   task automatic chk_mode(input int m, input int pulse, input string tag);
      check(mode_status, m, {tag, " R1 status"});
      check(sys_osc_en, (m == 0 || m == 1), {tag, " R7 sys_osc"});
      check(sub_osc_en, 1, {tag, " R7 sub_osc"});
      check(cpu_clk_en, (m == 0 || m == 2), {tag, " R8 cpu_clk"});
      check(periph_rst, (m >= 2) ? 7 : 0, {tag, " R9 periph_rst"});
      check(io_hiz, (m == 4), {tag, " R10 io_hiz"});
      check(wake_pulse, pulse, {tag, " R6 wake_pulse"});
   endtask

   task automatic pulse_sleep(input logic stby);
      standby_sel = stby;
      sleep_req   = 1'b1;
      step();
      sleep_req   = 1'b0;
   endtask

   task automatic wake_src(input int idx, input logic dest);
      low_speed_sel = dest;
      irq_mask      = 1'b0;
      irq_en        = '0;
      irq_req       = '0;
      irq_en[idx]   = 1'b1;
      irq_req[idx]  = 1'b1;
      step();
      irq_req       = '0;
   endtask

   task automatic t_reset();
      chk_mode(0, 0, "reset");
      check(periph_div, 0, "reset R11 div");
   endtask

   task automatic t_sleep_wake_active();
      div_sel = 3'd5;
      pulse_sleep(1'b0);
      chk_mode(1, 0, "R2 sleep entry");
      check(periph_div, 5, "R11 div captured");
      div_sel = 3'd2;
      step();
      check(periph_div, 5, "R11 div held");
      wake_src(3, 1'b0);
      chk_mode(0, 1, "R5 wake to active");
      check(periph_div, 0, "R11 div zero in active");
      step();
      chk_mode(0, 0, "R6 pulse one cycle");
   endtask

   task automatic t_masked();
      pulse_sleep(1'b0);
      chk_mode(1, 0, "R2 sleep again");
      // global mask set
      irq_mask = 1'b1; irq_en = 8'hFF; irq_req = 8'hFF;
      step();
      chk_mode(1, 0, "R4 masked stays");
      // request without enable
      irq_mask = 1'b0; irq_en = 8'h0F; irq_req = 8'hF0;
      step();
      chk_mode(1, 0, "R4 disabled source stays");
      // matching pair on bit 6 wakes to subactive
      irq_en = 8'h40; irq_req = 8'h40; low_speed_sel = 1'b1;
      step();
      irq_req = '0;
      chk_mode(2, 1, "R4 R5 wake to subactive");
      step();
      chk_mode(2, 0, "R6 pulse ends");
   endtask

   task automatic t_subactive_paths();
      pulse_sleep(1'b0);
      chk_mode(3, 0, "R3 subsleep entry");
      check(periph_div, 0, "R11 div zero in subsleep");
      wake_src(0, 1'b1);
      chk_mode(2, 1, "R5 subsleep to subactive");
      pulse_sleep(1'b1);
      chk_mode(4, 0, "R3 standby from subactive");
      wake_src(7, 1'b0);
      chk_mode(0, 1, "R5 standby to active");
   endtask

   task automatic t_standby_from_active();
      pulse_sleep(1'b1);
      chk_mode(4, 0, "R2 standby from active");
      pulse_sleep(1'b0);
      chk_mode(4, 0, "R12 sleep_req ignored in standby");
      wake_src(1, 1'b1);
      chk_mode(2, 1, "R5 standby to subactive");
      step();
   endtask

   task automatic t_ignore_running();
      irq_mask = 1'b0; irq_en = 8'hFF; irq_req = 8'hFF; low_speed_sel = 1'b0;
      step();
      chk_mode(2, 0, "R12 wake ignored in subactive");
      irq_req = '0;
      wake_src(2, 1'b0);   // leave subactive? no: still running, must stay
      chk_mode(2, 0, "R12 still subactive");
   endtask

   task automatic t_collision();
      // get to active: subsleep then wake to active
      pulse_sleep(1'b0);
      wake_src(4, 1'b0);
      chk_mode(0, 1, "R5 back to active");
      // qualified wake and entry together in sleep: exit wins
      pulse_sleep(1'b0);
      chk_mode(1, 0, "R2 sleep before collision");
      irq_mask = 1'b0; irq_en = 8'h02; irq_req = 8'h02; low_speed_sel = 1'b0;
      standby_sel = 1'b1; sleep_req = 1'b1;
      step();
      sleep_req = 1'b0; irq_req = '0;
      chk_mode(0, 1, "R12 exit wins over entry in sleep");
      // pending wake while entering from active: one sleep cycle, then exit
      div_sel = 3'd6; irq_req = 8'h02; standby_sel = 1'b0; sleep_req = 1'b1;
      step();
      sleep_req = 1'b0;
      chk_mode(1, 0, "R2 entry despite pending wake");
      check(periph_div, 6, "R11 div during brief sleep");
      step();
      irq_req = '0;
      chk_mode(0, 1, "R4 immediate exit");
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; sleep_req = 1'b0; standby_sel = 1'b0; low_speed_sel = 1'b0;
      irq_mask = 1'b1; irq_req = '0; irq_en = '0; div_sel = '0;
      step(); step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_sleep_wake_active();
      t_masked();
      t_subactive_paths();
      t_standby_from_active();
      // now in subactive
      t_ignore_running();
      t_collision();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule